// File: doc/BRIEF.md
# Pixel Binarizer and Frame Packetizer

The block accepts a stream of grayscale camera pixels and compares each one with a threshold that the user sets. Each pixel becomes one bit: bright (1) or dark (0). The bits are packed into bytes, most significant bit first. Every frame is cut into `PKTS` equal chunks of whole image lines, and every chunk is offered downstream as one packet payload. Each payload byte carries its packet number, counted from 0 within the frame, together with first and last markers. A byte FIFO sits between the packer and the output. A later stage can therefore hold back or delay packets while pixel intake goes on at full rate.

A frame begins at a pixel that has `pix_sof` high together with `pix_valid`. The packer is a two-state machine. In `ST_WAIT_SOF` it ignores pixels. The transition *frame start* (valid pixel with `pix_sof`) moves it to `ST_PACK`. In `ST_PACK` it counts bits, bytes and packets. The transition *frame restart* (a valid pixel with `pix_sof` while already in `ST_PACK`) keeps it in `ST_PACK`, clears all counters and drops any partial byte. The transition *frame end* (the last pixel of packet `PKTS-1`) returns it to `ST_WAIT_SOF`. A byte that finds the FIFO full is dropped, and a sticky overflow flag is raised that only reset clears.

With the default parameters (640 by 480 pixels, 60 packets), each packet covers 8 lines, which is 640 payload bytes.

Top module: `pixbin_top`

## Requirements
- R1: A pixel yields bit 1 when its value is greater than or equal to `thresh`, and bit 0 otherwise.
- R2: Bits are packed MSB-first. The earliest of each eight accepted pixels lands in bit 7 of `m_data` and the latest lands in bit 0.
- R3: Each packet holds exactly `IMG_W*(IMG_H/PKTS)/8` bytes. `m_first`=1 marks only its first byte and `m_last`=1 marks only its last byte.
- R4: Within a frame, `m_pkt` counts 0, 1, …, `PKTS-1` in order, one value per packet, and the frame yields exactly `PKTS` packets.
- R5: A valid pixel with `pix_sof` always starts a new frame. That pixel becomes bit 7 of byte 0 of packet 0, and an unfinished byte of the previous frame is discarded.
- R6: Valid pixels without `pix_sof` after reset, or after the final pixel of a frame, produce no output.
- R7: Output bytes leave in the order they were packed. While `m_valid`=1 and `m_ready`=0, `m_valid` stays 1 and `m_data`, `m_pkt`, `m_first` and `m_last` hold their values.
- R8: A byte completed while the FIFO is full is dropped and sets `overflow` to 1. The flag stays 1 until reset. Bytes already stored are still delivered unchanged.
- R9: After reset `m_valid`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | PIX_W | Brightness threshold |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | PIX_W | Pixel value |
| pix_sof | input | 1 | Marks the first pixel of a frame (qualified by pix_valid) |
| m_valid | output | 1 | Output byte available |
| m_ready | input | 1 | Downstream accepts the byte |
| m_data | output | 8 | Packed payload byte, MSB = earliest pixel |
| m_pkt | output | PN_W = clog2(PKTS) | Packet number within the frame |
| m_first | output | 1 | Byte is first of its packet |
| m_last | output | 1 | Byte is last of its packet |
| overflow | output | 1 | Sticky: a byte was dropped on a full FIFO |

## Verification
The following rules are checked on every cycle:
- after a frame start, all counters are cleared;
- a first marker always follows a last marker;
- packet numbers stay in range;
- a stalled output holds steady;
- a drop on a full FIFO raises a sticky flag.

The bench's scenarios are needed for the rest:
- the threshold boundary, including pixels equal to it and one below it;
- bit order inside a byte, and whole-frame packet counts;
- discarding a partial byte on restart, and ignoring pixels before a frame starts;
- correct delivery of the stored bytes after an overflow.

// File: rtl/pixbin_pkg.sv
package pixbin_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_WAIT_SOF = 1'b0,
        ST_PACK     = 1'b1
    } pk_state_e;

    function automatic int cw(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pixbin_cmp.sv
module pixbin_cmp #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] thresh,
    output logic             bright
);
    // bright when at or above the threshold
    assign bright = (pix >= thresh);
endmodule

// File: rtl/pixbin_packer.sv
module pixbin_packer
    import pixbin_pkg::*;
#(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int PKTS  = 60,
    parameter int PN_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_valid,
    input  logic                pix_sof,
    input  logic                pix_bit,
    output logic                wr_en,
    output logic [BYTE_W-1:0]   wr_byte,
    output logic [PN_W-1:0]     wr_pkt,
    output logic                wr_first,
    output logic                wr_last
);
    localparam int LINES = IMG_H / PKTS;
    localparam int BPP   = (IMG_W * LINES) / BYTE_W;
    localparam int BYW   = cw(BPP);
    localparam int BIW   = cw(BYTE_W);

    pk_state_e state, state_nx;
    logic [BIW-1:0]    bit_idx;
    logic [BYW-1:0]    byte_idx;
    logic [PN_W-1:0]   pkt_idx;
    logic [BYTE_W-2:0] sr;

    logic              start, take, byte_done, pkt_done, frame_done;
    logic [BIW-1:0]    eff_bit;
    logic [BYW-1:0]    eff_byte;
    logic [PN_W-1:0]   eff_pkt;
    logic [BYTE_W-2:0] eff_sr;

    // effective counters: a frame start overrides the stored ones
    always_comb begin
        start      = pix_valid && pix_sof;
        take       = pix_valid && (pix_sof || state == ST_PACK);
        eff_bit    = start ? '0 : bit_idx;
        eff_byte   = start ? '0 : byte_idx;
        eff_pkt    = start ? '0 : pkt_idx;
        eff_sr     = start ? '0 : sr;
        byte_done  = take && (eff_bit == BIW'(BYTE_W - 1));
        pkt_done   = byte_done && (eff_byte == BYW'(BPP - 1));
        frame_done = pkt_done && (eff_pkt == PN_W'(PKTS - 1));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_SOF: if (start)      state_nx = ST_PACK;
            ST_PACK:     if (frame_done) state_nx = ST_WAIT_SOF;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT_SOF;
            bit_idx  <= '0;
            byte_idx <= '0;
            pkt_idx  <= '0;
            sr       <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                sr      <= {eff_sr[BYTE_W-3:0], pix_bit};
                bit_idx <= byte_done ? '0 : BIW'(eff_bit + 1'b1);
                if (byte_done) begin
                    byte_idx <= pkt_done ? '0 : BYW'(eff_byte + 1'b1);
                end else begin
                    byte_idx <= eff_byte;
                end
                if (frame_done) begin
                    pkt_idx <= '0;
                end else if (pkt_done) begin
                    pkt_idx <= PN_W'(eff_pkt + 1'b1);
                end else begin
                    pkt_idx <= eff_pkt;
                end
            end
        end
    end

    // outputs
    always_comb begin
        wr_en    = byte_done;
        wr_byte  = {eff_sr, pix_bit};
        wr_pkt   = eff_pkt;
        wr_first = (eff_byte == '0);
        wr_last  = (eff_byte == BYW'(BPP - 1));
    end

    // checker state: was the last emitted byte a packet end
    logic prev_last;
    always_ff @(posedge clk) begin
        if (!rst_n)     prev_last <= 1'b1;
        else if (wr_en) prev_last <= wr_last;
    end

    a_r5_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sof) |=> (state == ST_PACK && bit_idx == BIW'(1) &&
                                    byte_idx == '0 && pkt_idx == '0));

    a_r3_first_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prev_last) |-> wr_first);

    a_r4_pkt_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_pkt <= PN_W'(PKTS - 1)));

endmodule

// File: rtl/pixbin_fifo.sv
module pixbin_fifo
    import pixbin_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);
    localparam int AW = cw(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign full     = (cnt == CW'(DEPTH));
    assign rd_valid = (cnt != '0);
    assign push     = wr_en && !full;
    assign pop      = rd_valid && rd_ready;
    assign rd_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= AW'(wr_ptr + 1'b1);
            if (pop)  rd_ptr <= AW'(rd_ptr + 1'b1);
            cnt <= CW'(cnt + CW'(push) - CW'(pop));
        end
    end

    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    a_r8_full_stays_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

endmodule

// File: rtl/pixbin_top.sv
module pixbin_top
    import pixbin_pkg::*;
#(
    parameter int IMG_W      = 640,
    parameter int IMG_H      = 480,
    parameter int PKTS       = 60,
    parameter int PIX_W      = 8,
    parameter int FIFO_DEPTH = 1024,
    localparam int PN_W      = cw(PKTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  thresh,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_sof,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [BYTE_W-1:0] m_data,
    output logic [PN_W-1:0]   m_pkt,
    output logic              m_first,
    output logic              m_last,
    output logic              overflow
);
    localparam int EW = PN_W + 2 + BYTE_W;

    logic              pix_bit;
    logic              pk_wr, pk_first, pk_last;
    logic [BYTE_W-1:0] pk_byte;
    logic [PN_W-1:0]   pk_pkt;
    logic              fifo_full;
    logic [EW-1:0]     rd_entry;

    pixbin_cmp #(.PIX_W(PIX_W)) cmp_i (
        .pix    (pix_data),
        .thresh (thresh),
        .bright (pix_bit)
    );

    pixbin_packer #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .PKTS(PKTS), .PN_W(PN_W)
    ) packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_sof   (pix_sof),
        .pix_bit   (pix_bit),
        .wr_en     (pk_wr),
        .wr_byte   (pk_byte),
        .wr_pkt    (pk_pkt),
        .wr_first  (pk_first),
        .wr_last   (pk_last)
    );

    pixbin_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pk_wr),
        .wr_data  ({pk_pkt, pk_first, pk_last, pk_byte}),
        .full     (fifo_full),
        .rd_valid (m_valid),
        .rd_ready (m_ready),
        .rd_data  (rd_entry)
    );

    assign {m_pkt, m_first, m_last, m_data} = rd_entry;

    always_ff @(posedge clk) begin
        if (!rst_n)                  overflow <= 1'b0;
        else if (pk_wr && fifo_full) overflow <= 1'b1;
    end

    a_r8_ovf_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_wr && fifo_full) |=> overflow);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: tb/pixbin_top_tb_top.sv
module pixbin_top_tb_top;
    localparam int IMG_W = 16;
    localparam int IMG_H = 8;
    localparam int PKTS  = 4;
    localparam int DEPTH = 8;
    localparam int NPIX  = IMG_W * IMG_H;
    localparam int NBYTE = NPIX / 8;
    localparam int BPP   = NBYTE / PKTS;
    localparam int PN_W  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      thresh = 8'd128;
    logic            pix_valid = 1'b0;
    logic [7:0]      pix_data = 8'd0;
    logic            pix_sof = 1'b0;
    logic            m_valid;
    logic            m_ready = 1'b1;
    logic [7:0]      m_data;
    logic [PN_W-1:0] m_pkt;
    logic            m_first, m_last, overflow;

    always #10 clk = ~clk;

    pixbin_top #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .PKTS(PKTS), .PIX_W(8), .FIFO_DEPTH(DEPTH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .thresh(thresh), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_sof(pix_sof), .m_valid(m_valid),
        .m_ready(m_ready), .m_data(m_data), .m_pkt(m_pkt), .m_first(m_first),
        .m_last(m_last), .overflow(overflow)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] fpx [NPIX];
    int q_data[$];
    int q_pkt[$];
    int q_first[$];
    int q_last[$];

    // capture transfers: sampled after inputs settle, before the next edge
    always @(negedge clk) begin
        #2;
        if (rst_n && m_valid && m_ready) begin
            q_data.push_back(int'(m_data));
            q_pkt.push_back(int'(m_pkt));
            q_first.push_back(int'(m_first));
            q_last.push_back(int'(m_last));
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_byte(int k);
        int b = 0;
        for (int j = 0; j < 8; j++) b = (b << 1) | ((fpx[8*k+j] >= thresh) ? 1 : 0);
        return b;
    endfunction

    task automatic clear_q();
        q_data.delete(); q_pkt.delete(); q_first.delete(); q_last.delete();
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic drive_frame(int npix, bit gap);
        for (int i = 0; i < npix; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; pix_data = fpx[i]; pix_sof = (i == 0);
            if (gap) begin
                @(negedge clk);
                pix_valid = 1'b0; pix_sof = 1'b0;
            end
        end
        @(negedge clk);
        pix_valid = 1'b0; pix_sof = 1'b0;
    endtask

    task automatic drive_loose(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; pix_data = 8'd255; pix_sof = 1'b0;
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    // compare queue entries [qb, qb+n) against frame bytes [0, n)
    task automatic check_bytes(string req, int qb, int n);
        bit ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (q_data[qb+k] != exp_byte(k) || q_pkt[qb+k] != k / BPP ||
                q_first[qb+k] != ((k % BPP) == 0 ? 1 : 0) ||
                q_last[qb+k] != ((k % BPP) == BPP - 1 ? 1 : 0)) begin
                ok = 1'b0;
                $display("FAIL %s byte %0d: actual data %0d pkt %0d f%0d l%0d expected data %0d pkt %0d",
                         req, k, q_data[qb+k], q_pkt[qb+k], q_first[qb+k], q_last[qb+k],
                         exp_byte(k), k / BPP);
            end
        end
        n_cmp++;
        if (!ok) n_bad++;
    endtask

    task automatic fill_pattern(int mul, int add);
        for (int i = 0; i < NPIX; i++) fpx[i] = 8'((i * mul + add) & 255);
    endtask

    task automatic t_reset();
        check_eq("R9", "m_valid after reset", int'(m_valid), 0);
        check_eq("R9", "overflow after reset", int'(overflow), 0);
    endtask

    task automatic t_basic();
        fill_pattern(37, 11);
        fpx[0] = 8'd128; fpx[1] = 8'd127; fpx[2] = 8'd255; fpx[3] = 8'd0;
        thresh = 8'd128;
        clear_q();
        drive_frame(NPIX, 1'b0);
        settle();
        check_eq("R4", "byte count of one frame", q_data.size(), NBYTE);
        if (q_data.size() == NBYTE) begin
            check_bytes("R1 R2 R3 R4", 0, NBYTE);
            // first byte MSB-first: 128>=128 ->1, 127 ->0, 255 ->1, 0 ->0
            check_eq("R2", "top nibble of byte 0", q_data[0] >> 4, exp_byte(0) >> 4);
            check_eq("R1", "pixel equal to threshold in bit 7", (q_data[0] >> 7) & 1, 1);
            check_eq("R1", "pixel one below threshold in bit 6", (q_data[0] >> 6) & 1, 0);
            check_eq("R4", "packet number of last byte", q_pkt[NBYTE-1], PKTS - 1);
        end
    endtask

    task automatic t_thresholds();
        fill_pattern(53, 7);
        thresh = 8'd0;
        clear_q();
        drive_frame(NPIX, 1'b1);
        settle();
        check_eq("R1", "byte count at threshold 0", q_data.size(), NBYTE);
        if (q_data.size() == NBYTE) begin
            check_eq("R1", "byte 5 at threshold 0", q_data[5], 255);
            check_bytes("R1", 0, NBYTE);
        end
        for (int i = 0; i < NPIX; i += 5) fpx[i] = 8'd255;
        fpx[1] = 8'd254;
        thresh = 8'd255;
        clear_q();
        drive_frame(NPIX, 1'b0);
        settle();
        check_eq("R1", "byte count at threshold 255", q_data.size(), NBYTE);
        if (q_data.size() == NBYTE) check_bytes("R1", 0, NBYTE);
    endtask

    task automatic t_ignore();
        fill_pattern(29, 3);
        thresh = 8'd100;
        clear_q();
        drive_loose(20);
        settle();
        check_eq("R6", "bytes from pixels before frame start", q_data.size(), 0);
        drive_frame(NPIX, 1'b0);
        drive_loose(24);
        settle();
        check_eq("R6", "bytes with trailing pixels after frame end", q_data.size(), NBYTE);
        if (q_data.size() == NBYTE) check_bytes("R6", 0, NBYTE);
    endtask

    task automatic t_restart();
        fill_pattern(71, 40);
        thresh = 8'd90;
        clear_q();
        drive_frame(44, 1'b0);
        drive_frame(NPIX, 1'b0);
        settle();
        check_eq("R5", "bytes from partial plus full frame", q_data.size(), 5 + NBYTE);
        if (q_data.size() == 5 + NBYTE) begin
            check_bytes("R5", 0, 5);
            check_bytes("R5", 5, NBYTE);
            check_eq("R5", "packet number after restart", q_pkt[5], 0);
            check_eq("R5", "first flag after restart", q_first[5], 1);
        end
    endtask

    task automatic t_backpressure();
        fill_pattern(13, 200);
        thresh = 8'd140;
        clear_q();
        fork
            drive_frame(NPIX, 1'b0);
            begin
                for (int c = 0; c < 200; c++) begin
                    @(negedge clk);
                    m_ready = ((c % 3) != 0);
                end
                @(negedge clk);
                m_ready = 1'b1;
            end
        join
        settle();
        check_eq("R7", "byte count under back-pressure", q_data.size(), NBYTE);
        if (q_data.size() == NBYTE) check_bytes("R7", 0, NBYTE);
        check_eq("R8", "no overflow when drained in time", int'(overflow), 0);
        // stall and hold
        @(negedge clk);
        m_ready = 1'b0;
        drive_frame(16, 1'b0);
        repeat (3) @(negedge clk);
        #2;
        check_eq("R7", "valid while stalled", int'(m_valid), 1);
        check_eq("R7", "stalled data is byte 0", int'(m_data), exp_byte(0));
        repeat (4) @(negedge clk);
        #2;
        check_eq("R7", "valid still held", int'(m_valid), 1);
        check_eq("R7", "data still held", int'(m_data), exp_byte(0));
        check_eq("R7", "first flag held", int'(m_first), 1);
        @(negedge clk);
        m_ready = 1'b1;
        settle();
    endtask

    task automatic t_overflow();
        fill_pattern(97, 5);
        thresh = 8'd120;
        clear_q();
        @(negedge clk);
        m_ready = 1'b0;
        drive_frame(NPIX, 1'b0);
        settle();
        check_eq("R8", "overflow after full frame into stalled output", int'(overflow), 1);
        @(negedge clk);
        m_ready = 1'b1;
        settle();
        check_eq("R8", "bytes kept by the FIFO", q_data.size(), DEPTH);
        if (q_data.size() == DEPTH) check_bytes("R8", 0, DEPTH);
        check_eq("R8", "overflow stays set", int'(overflow), 1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        t_reset();
        t_basic();
        t_thresholds();
        t_ignore();
        t_restart();
        t_backpressure();
        t_overflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule